// File: doc/BRIEF.md
# Prioritizing Interrupt Distributor with Core Routing

This block gathers interrupt requests and presents to each core the single most urgent one that core may take. Interrupt numbers fall into three classes. Numbers 0 to 15 are software interrupts, raised by a per-core request input. Numbers 16 to 31 are private peripheral lines that each core owns. Numbers from 32 up to 31+`NUM_SPI` are shared lines, and each of them is steered to one core by its routing value. Private and software settings are banked: each core has its own copy. Shared settings exist once.

Each interrupt has these settings: an enable, a 5-bit priority, level or edge triggering, and a group. The group decides whether it drives the core's FIQ output or its IRQ output. A disabled interrupt still becomes pending, so enabling it later delivers it. For every core, an arbiter picks among the pending interrupts. It considers only interrupts that are enabled, whose group is enabled, and whose priority passes that core's mask. It shows the winner's number and priority on every cycle. Software programs all of this through a flat register port that writes in one cycle and reads combinationally. Pending state is cleared through a per-core acknowledge input. That input is a plain strobe with no back-pressure: it is accepted in the cycle it is high.

Register fields are selected by `reg_field`, and the interrupt by `reg_id`. For numbers below 32, `reg_core` selects the bank. Data sits at the low bits of `reg_wdata` and `reg_rdata`. `NUM_CORES` and `NUM_SPI` must be powers of two, and `NUM_CORES` must be at least 2.

Top module: `irq_distrib`

## Requirements
- R1: IDs 0–15 are software interrupts, 16–31 are per-core private lines (`ppi_lines[c*16 + id-16]`), and 32..31+NUM_SPI are shared lines (`spi_lines[id-32]`). Every private and software setting is held per core, and the register port selects the copy with `reg_core`. A private line of one core never reaches another core.
- R2: Field 1 (set-enable) with `reg_wdata[0]`=1 enables the addressed ID. Field 2 (clear-enable) with `reg_wdata[0]`=1 disables it. A write with bit 0 = 0 to either field changes nothing. Reading field 1 or field 2 returns the enable in bit 0. All enables reset to 0.
- R3: An interrupt that fires while disabled becomes pending and stays pending. Once it is enabled, it is delivered without a new event.
- R4: Field 4 bit 0 selects edge (1) or level (0) triggering, and resets to level. In edge mode, a rising edge latches pending, and the latch holds after the line falls. In level mode, pending follows the line, and an acknowledge does not clear it.
- R5: Field 3 holds a 5-bit priority, reset 0, where a lower value wins. On equal priority the lower ID wins. `best_valid`, `best_id` and `best_prio` show the winner of each core on every cycle.
- R6: Field 7 is the per-core priority mask, selected by `reg_core`, 8 bits, reset 0xFF. Only an interrupt whose priority is strictly below the mask takes part in arbitration.
- R7: Field 0 is the control register. Bit 0 enables group 0 and bit 1 enables group 1; both reset to 0. Bit 2 always reads 1 and ignores writes. Interrupts of a disabled group are not signalled.
- R8: Field 5 bit 0 is the group, reset 0. Group 0 signals `fiq`, and group 1 signals `irq`. `irq` and `fiq` follow the winner's group and are never high together.
- R9: Field 6 is the 8-bit route of a shared interrupt, reset 0. The interrupt reaches only the core whose index equals the route. For private IDs the field reads 0.
- R10: `ack_valid[c]` with `ack_id` clears the pending latch of that ID on core c. A shared ID is cleared only by the core it is routed to. An edge interrupt then stays clear until its next rising edge. A new event in the same cycle as the acknowledge wins.
- R11: `sgi_valid[c]` with `sgi_id[c*4+:4]` sets the pending bit of that software ID on core c only. Software interrupts are always latched, whatever their trigger setting.
- R12: Lines are sampled on the clock edge, so a change shows on the outputs after one rising edge. Register writes take effect at the edge, and `reg_rdata` is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_lines | input | NUM_SPI | Shared interrupt lines, IDs 32 upward |
| ppi_lines | input | NUM_CORES*16 | Private lines, 16 per core |
| sgi_valid | input | NUM_CORES | Software interrupt request strobe per core |
| sgi_id | input | NUM_CORES*4 | Software interrupt ID per core |
| ack_valid | input | NUM_CORES | Acknowledge strobe per core |
| ack_id | input | NUM_CORES*ID_W | Acknowledged ID per core |
| reg_wr | input | 1 | Register write strobe |
| reg_core | input | CORE_W | Bank select for private settings and the mask |
| reg_field | input | 3 | Register field select |
| reg_id | input | ID_W | Interrupt ID addressed |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq | output | NUM_CORES | Winner is group 1 |
| fiq | output | NUM_CORES | Winner is group 0 |
| best_valid | output | NUM_CORES | A candidate exists for the core |
| best_id | output | NUM_CORES*ID_W | Winning ID per core |
| best_prio | output | NUM_CORES*5 | Winning priority per core |

## Verification
On every cycle, the assertions check the arbiter's choice against every candidate, including the lower-ID rule on equal priority. They also check that `irq` and `fiq` never rise together, that a signalled winner is below its mask and belongs to an enabled group, and that an edge latch holds until it is acknowledged. Only the bench scenarios can show the register semantics: the write-one-to-set and write-one-to-clear enables, the control bit that reads one, and the banking of private settings. The same holds for a disabled interrupt being delivered late, for routing switched between cores, for level lines surviving an acknowledge, and for the one-edge latency.

// File: rtl/irq_distrib_pkg.sv
package irq_distrib_pkg;
  localparam int PRIO_W    = 5;
  localparam int PRIV_IDS  = 32;
  localparam int SOFT_IDS  = 16;
  localparam int REG_DW    = 8;

  typedef enum logic [2:0] {
    F_CTRL  = 3'd0,
    F_SETEN = 3'd1,
    F_CLREN = 3'd2,
    F_PRIO  = 3'd3,
    F_TRIG  = 3'd4,
    F_GROUP = 3'd5,
    F_ROUTE = 3'd6,
    F_MASK  = 3'd7
  } reg_field_e;
endpackage

// File: rtl/irq_src.sv
module irq_src (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic is_edge,
  input  logic set_sw,
  input  logic clr,
  output logic pending
);
  logic line_q;
  logic latch_q;
  logic rise;

  assign rise = line & ~line_q & is_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      line_q  <= line;
      latch_q <= (latch_q & ~clr) | rise | set_sw;
    end
  end

  assign pending = is_edge ? latch_q : line_q;

  // R3 / R4: a latched edge event persists until acknowledged
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && pending && !clr) |=> (pending || !is_edge));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 48,
  parameter int PW = 5,
  parameter int IW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand,
  input  logic [N-1:0]    grp,
  input  logic [N*PW-1:0] prio_flat,
  output logic            valid,
  output logic [IW-1:0]   id,
  output logic [PW-1:0]   prio,
  output logic            win_grp
);
  always_comb begin
    valid   = 1'b0;
    id      = '0;
    prio    = '0;
    win_grp = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!valid || prio_flat[i*PW +: PW] < prio)) begin
        valid   = 1'b1;
        id      = IW'(i);
        prio    = prio_flat[i*PW +: PW];
        win_grp = grp[i];
      end
    end
  end

  p_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |-> valid);

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R5: no candidate beats the winner; ties go to the lower ID
    p_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cand[g] |-> (valid && (prio < prio_flat[g*PW +: PW] ||
                   (prio == prio_flat[g*PW +: PW] && id <= IW'(g)))));
  end
endmodule

// File: rtl/irq_distrib.sv
module irq_distrib
  import irq_distrib_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int NUM_SPI   = 16,
  localparam int NTOT     = PRIV_IDS + NUM_SPI,
  localparam int ID_W     = $clog2(NTOT),
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SPI-1:0]          spi_lines,
  input  logic [NUM_CORES*16-1:0]     ppi_lines,
  input  logic [NUM_CORES-1:0]        sgi_valid,
  input  logic [NUM_CORES*4-1:0]      sgi_id,
  input  logic [NUM_CORES-1:0]        ack_valid,
  input  logic [NUM_CORES*ID_W-1:0]   ack_id,
  input  logic                        reg_wr,
  input  logic [CORE_W-1:0]           reg_core,
  input  logic [2:0]                  reg_field,
  input  logic [ID_W-1:0]             reg_id,
  input  logic [REG_DW-1:0]           reg_wdata,
  output logic [REG_DW-1:0]           reg_rdata,
  output logic [NUM_CORES-1:0]        irq,
  output logic [NUM_CORES-1:0]        fiq,
  output logic [NUM_CORES-1:0]        best_valid,
  output logic [NUM_CORES*ID_W-1:0]   best_id,
  output logic [NUM_CORES*PRIO_W-1:0] best_prio
);
  localparam int SPI_W = $clog2(NUM_SPI);

  // banked private settings
  logic [PRIV_IDS-1:0] p_en   [NUM_CORES];
  logic [PRIV_IDS-1:0] p_edge [NUM_CORES];
  logic [PRIV_IDS-1:0] p_grp  [NUM_CORES];
  logic [PRIO_W-1:0]   p_prio [NUM_CORES][PRIV_IDS];
  logic [PRIV_IDS-1:0] p_pend [NUM_CORES];
  // shared settings
  logic [NUM_SPI-1:0]  s_en, s_edge, s_grp, s_pend;
  logic [PRIO_W-1:0]   s_prio  [NUM_SPI];
  logic [REG_DW-1:0]   s_route [NUM_SPI];
  logic [REG_DW-1:0]   pmr     [NUM_CORES];
  logic                grp0_en, grp1_en;

  // register decode
  reg_field_e         fsel;
  logic               is_priv, is_spi;
  logic [4:0]         pidx;
  logic [ID_W-1:0]    soff;
  logic [SPI_W-1:0]   sidx;

  assign fsel    = reg_field_e'(reg_field);
  assign is_priv = reg_id < ID_W'(PRIV_IDS);
  assign soff    = reg_id - ID_W'(PRIV_IDS);
  assign is_spi  = !is_priv && (soff < ID_W'(NUM_SPI));
  assign pidx    = reg_id[4:0];
  assign sidx    = soff[SPI_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp0_en <= 1'b0;
      grp1_en <= 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
        p_en[c]   <= '0;
        p_edge[c] <= '0;
        p_grp[c]  <= '0;
        pmr[c]    <= 8'hFF;
        for (int i = 0; i < PRIV_IDS; i++) p_prio[c][i] <= '0;
      end
      s_en   <= '0;
      s_edge <= '0;
      s_grp  <= '0;
      for (int s = 0; s < NUM_SPI; s++) begin
        s_prio[s]  <= '0;
        s_route[s] <= '0;
      end
    end else if (reg_wr) begin
      case (fsel)
        F_CTRL: begin
          grp0_en <= reg_wdata[0];
          grp1_en <= reg_wdata[1];
        end
        F_SETEN: if (reg_wdata[0]) begin
          if (is_priv)     p_en[reg_core][pidx] <= 1'b1;
          else if (is_spi) s_en[sidx]           <= 1'b1;
        end
        F_CLREN: if (reg_wdata[0]) begin
          if (is_priv)     p_en[reg_core][pidx] <= 1'b0;
          else if (is_spi) s_en[sidx]           <= 1'b0;
        end
        F_PRIO: begin
          if (is_priv)     p_prio[reg_core][pidx] <= reg_wdata[PRIO_W-1:0];
          else if (is_spi) s_prio[sidx]           <= reg_wdata[PRIO_W-1:0];
        end
        F_TRIG: begin
          if (is_priv)     p_edge[reg_core][pidx] <= reg_wdata[0];
          else if (is_spi) s_edge[sidx]           <= reg_wdata[0];
        end
        F_GROUP: begin
          if (is_priv)     p_grp[reg_core][pidx] <= reg_wdata[0];
          else if (is_spi) s_grp[sidx]           <= reg_wdata[0];
        end
        F_ROUTE: if (is_spi) s_route[sidx] <= reg_wdata;
        F_MASK:  pmr[reg_core] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (fsel)
      F_CTRL: reg_rdata = {5'b0, 1'b1, grp1_en, grp0_en};
      F_SETEN, F_CLREN:
        reg_rdata[0] = is_priv ? p_en[reg_core][pidx] : (is_spi & s_en[sidx]);
      F_PRIO:
        if (is_priv)     reg_rdata[PRIO_W-1:0] = p_prio[reg_core][pidx];
        else if (is_spi) reg_rdata[PRIO_W-1:0] = s_prio[sidx];
      F_TRIG:
        reg_rdata[0] = is_priv ? p_edge[reg_core][pidx] : (is_spi & s_edge[sidx]);
      F_GROUP:
        reg_rdata[0] = is_priv ? p_grp[reg_core][pidx] : (is_spi & s_grp[sidx]);
      F_ROUTE: if (is_spi) reg_rdata = s_route[sidx];
      F_MASK:  reg_rdata = pmr[reg_core];
      default: ;
    endcase
  end

  // pending sources: banked private, then shared
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_src
    for (genvar i = 0; i < PRIV_IDS; i++) begin : g_priv
      logic ln, edg, sw, clr;
      if (i < SOFT_IDS) begin : g_soft
        assign ln  = 1'b0;
        assign edg = 1'b1;
        assign sw  = sgi_valid[c] && (sgi_id[c*4 +: 4] == 4'(i));
      end else begin : g_ppi
        assign ln  = ppi_lines[c*16 + i - SOFT_IDS];
        assign edg = p_edge[c][i];
        assign sw  = 1'b0;
      end
      assign clr = ack_valid[c] && (ack_id[c*ID_W +: ID_W] == ID_W'(i));
      irq_src u_src (.clk(clk), .rst_n(rst_n), .line(ln), .is_edge(edg),
                     .set_sw(sw), .clr(clr), .pending(p_pend[c][i]));
    end
  end

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi_src
    logic clr;
    always_comb begin
      clr = 1'b0;
      for (int c = 0; c < NUM_CORES; c++)
        if (ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(PRIV_IDS + s) &&
            s_route[s] == REG_DW'(c))
          clr = 1'b1;
    end
    irq_src u_src (.clk(clk), .rst_n(rst_n), .line(spi_lines[s]), .is_edge(s_edge[s]),
                   .set_sw(1'b0), .clr(clr), .pending(s_pend[s]));
  end

  // per-core candidate filtering and arbitration
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NTOT-1:0]        cand, grpv;
    logic [NTOT*PRIO_W-1:0] pf;
    logic                   wgrp;

    always_comb begin
      for (int i = 0; i < PRIV_IDS; i++) begin
        grpv[i]               = p_grp[c][i];
        pf[i*PRIO_W +: PRIO_W] = p_prio[c][i];
        cand[i] = p_pend[c][i] && p_en[c][i] &&
                  (p_grp[c][i] ? grp1_en : grp0_en) &&
                  ({3'b0, p_prio[c][i]} < pmr[c]);
      end
      for (int s = 0; s < NUM_SPI; s++) begin
        grpv[PRIV_IDS+s]                    = s_grp[s];
        pf[(PRIV_IDS+s)*PRIO_W +: PRIO_W]   = s_prio[s];
        cand[PRIV_IDS+s] = s_pend[s] && s_en[s] && (s_route[s] == REG_DW'(c)) &&
                           (s_grp[s] ? grp1_en : grp0_en) &&
                           ({3'b0, s_prio[s]} < pmr[c]);
      end
    end

    irq_arbiter #(.N(NTOT), .PW(PRIO_W), .IW(ID_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .cand(cand), .grp(grpv), .prio_flat(pf),
      .valid(best_valid[c]), .id(best_id[c*ID_W +: ID_W]),
      .prio(best_prio[c*PRIO_W +: PRIO_W]), .win_grp(wgrp));

    assign irq[c] = best_valid[c] &  wgrp;
    assign fiq[c] = best_valid[c] & ~wgrp;

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq[c] && fiq[c]));
    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[c] || fiq[c]) |-> ({3'b0, best_prio[c*PRIO_W +: PRIO_W]} < pmr[c]));
    p_grp1_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> grp1_en);
    p_grp0_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fiq[c] |-> grp0_en);
  end
endmodule

// File: tb/sim_irq_distrib.sv
`timescale 1ns/1ps
module sim_irq_distrib;
  localparam int NC = 2;
  localparam int NS = 16;
  localparam int IW = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NS-1:0]  spi;
  logic [NC*16-1:0] ppi;
  logic [NC-1:0]  sgi_v;
  logic [NC*4-1:0] sgi_i;
  logic [NC-1:0]  ack_v;
  logic [NC*IW-1:0] ack_i;
  logic           reg_wr;
  logic [0:0]     reg_core;
  logic [2:0]     reg_field;
  logic [IW-1:0]  reg_id;
  logic [7:0]     wdata, rdata;
  logic [NC-1:0]  irq, fiq, bval;
  logic [NC*IW-1:0] bid;
  logic [NC*5-1:0] bprio;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  irq_distrib #(.NUM_CORES(NC), .NUM_SPI(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_lines(spi), .ppi_lines(ppi),
    .sgi_valid(sgi_v), .sgi_id(sgi_i), .ack_valid(ack_v), .ack_id(ack_i),
    .reg_wr(reg_wr), .reg_core(reg_core), .reg_field(reg_field), .reg_id(reg_id),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .fiq(fiq),
    .best_valid(bval), .best_id(bid), .best_prio(bprio));

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input int core, input int field, input int id, input int data);
    reg_wr = 1'b1; reg_core = 1'(core); reg_field = 3'(field);
    reg_id = IW'(id); wdata = 8'(data);
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int core, input int field, input int id, output int v);
    reg_core = 1'(core); reg_field = 3'(field); reg_id = IW'(id);
    #1 v = int'(rdata);
  endtask

  task automatic ack(input int core, input int id);
    ack_v[core] = 1'b1; ack_i[core*IW +: IW] = IW'(id);
    step(1);
    ack_v[core] = 1'b0;
  endtask

  // enable, group 1, priority for an ID on a core
  task automatic arm(input int core, input int id, input int pr);
    wr(core, 5, id, 1);
    wr(core, 3, id, pr);
    wr(core, 1, id, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; spi = '0; ppi = '0; sgi_v = '0; sgi_i = '0;
    ack_v = '0; ack_i = '0; reg_wr = 1'b0; reg_core = '0;
    reg_field = '0; reg_id = '0; wdata = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    check("R7 irq at reset", int'(irq), 0);
    check("R7 fiq at reset", int'(fiq), 0);
    check("R5 valid at reset", int'(bval), 0);
    rd(0, 0, 0, v); check("R7 ctrl reset", v, 4);
    wr(0, 0, 0, 0);
    rd(0, 0, 0, v); check("R7 ctrl bit2 write ignored", v, 4);
    rd(0, 7, 0, v); check("R6 mask reset core0", v, 255);
    rd(1, 7, 0, v); check("R6 mask reset core1", v, 255);
    rd(0, 3, 40, v); check("R5 prio reset", v, 0);
  endtask

  task automatic t_enable();
    int v;
    do_reset();
    wr(0, 0, 0, 2);
    wr(0, 5, 33, 1); wr(0, 4, 33, 1); wr(0, 3, 33, 4);
    spi[1] = 1'b1; step(1); spi[1] = 1'b0; step(2);
    check("R3 disabled not delivered", int'(irq[0]), 0);
    rd(0, 1, 33, v); check("R2 enable reset", v, 0);
    wr(0, 1, 33, 0);
    rd(0, 1, 33, v); check("R2 set-enable zero no effect", v, 0);
    wr(0, 1, 33, 1);
    check("R3 late enable delivers", int'(irq[0]), 1);
    check("R3 late enable id", int'(bid[0 +: IW]), 33);
    wr(0, 2, 33, 0);
    check("R2 clear-enable zero no effect", int'(irq[0]), 1);
    wr(0, 2, 33, 1);
    check("R2 clear-enable gates", int'(irq[0]), 0);
    rd(0, 2, 33, v); check("R2 enable readback", v, 0);
  endtask

  task automatic t_trig();
    do_reset();
    wr(0, 0, 0, 2);
    arm(0, 34, 2);
    spi[2] = 1'b1;
    #1 check("R12 not before edge", int'(bval[0]), 0);
    step(1);
    check("R12 after one edge", int'(bval[0]), 1);
    check("R4 level id", int'(bid[0 +: IW]), 34);
    ack(0, 34);
    check("R4 level survives ack", int'(bval[0]), 1);
    spi[2] = 1'b0; step(1);
    check("R4 level follows line", int'(bval[0]), 0);
    wr(0, 4, 34, 1);
    spi[2] = 1'b1; step(1); spi[2] = 1'b0; step(2);
    check("R4 edge latched after fall", int'(bval[0]), 1);
    ack(0, 34);
    check("R10 ack clears edge", int'(bval[0]), 0);
    step(2);
    check("R10 stays clear", int'(bval[0]), 0);
  endtask

  task automatic t_prio();
    do_reset();
    wr(0, 0, 0, 2);
    arm(0, 32, 6); arm(0, 33, 3); arm(0, 34, 3); arm(0, 35, 9);
    spi[3:0] = 4'hF; step(1);
    check("R5 tie lower id", int'(bid[0 +: IW]), 33);
    check("R5 best prio", int'(bprio[0 +: 5]), 3);
    spi[1] = 1'b0; step(1);
    check("R5 next of tie", int'(bid[0 +: IW]), 34);
    spi[2] = 1'b0; step(1);
    check("R5 lower value wins", int'(bid[0 +: IW]), 32);
    check("R5 prio 6", int'(bprio[0 +: 5]), 6);
    spi[0] = 1'b0; step(1);
    check("R5 last", int'(bid[0 +: IW]), 35);
  endtask

  task automatic t_mask();
    int v;
    do_reset();
    wr(0, 0, 0, 2);
    arm(0, 36, 7);
    spi[4] = 1'b1; step(1);
    check("R6 passes default mask", int'(irq[0]), 1);
    wr(0, 7, 0, 7);
    check("R6 equal mask blocks", int'(irq[0]), 0);
    wr(0, 7, 0, 8);
    check("R6 mask above passes", int'(irq[0]), 1);
    rd(1, 7, 0, v); check("R6 other core mask", v, 255);
  endtask

  task automatic t_group();
    do_reset();
    wr(0, 0, 0, 1);
    wr(0, 3, 37, 1); wr(0, 1, 37, 1);
    spi[5] = 1'b1; step(1);
    check("R8 group0 fiq", int'(fiq[0]), 1);
    check("R8 group0 not irq", int'(irq[0]), 0);
    wr(0, 0, 0, 0);
    check("R7 group0 disabled", int'(fiq[0]), 0);
    wr(0, 0, 0, 2);
    check("R7 other group enable", int'(fiq[0]), 0);
    wr(0, 5, 37, 1);
    check("R8 group1 irq", int'(irq[0]), 1);
    check("R8 group1 not fiq", int'(fiq[0]), 0);
  endtask

  task automatic t_route();
    int v;
    do_reset();
    wr(0, 0, 0, 2);
    arm(0, 38, 0);
    wr(0, 6, 38, 1);
    spi[6] = 1'b1; step(1);
    check("R9 routed core1", int'(irq[1]), 1);
    check("R9 core1 id", int'(bid[IW +: IW]), 38);
    check("R9 not core0", int'(irq[0]), 0);
    wr(0, 6, 38, 0);
    check("R9 reroute core0", int'(irq[0]), 1);
    check("R9 core1 off", int'(irq[1]), 0);
    rd(0, 6, 38, v); check("R9 route readback", v, 0);
  endtask

  task automatic t_private();
    int v;
    do_reset();
    wr(0, 0, 0, 2);
    arm(1, 5, 2);
    sgi_v[1] = 1'b1; sgi_i[7:4] = 4'd5; step(1); sgi_v[1] = 1'b0; step(1);
    check("R11 sgi core1", int'(irq[1]), 1);
    check("R11 sgi id", int'(bid[IW +: IW]), 5);
    arm(0, 5, 2);
    check("R11 sgi not on core0", int'(irq[0]), 0);
    rd(1, 3, 5, v); check("R1 banked prio core1", v, 2);
    rd(0, 4, 5, v); check("R11 trigger reads level", v, 0);
    ack(1, 5);
    check("R10 sgi acked", int'(irq[1]), 0);
    arm(0, 20, 1);
    ppi[16 + 4] = 1'b1; step(1);
    check("R1 core1 line not on core0", int'(irq[0]), 0);
    ppi[4] = 1'b1; step(1);
    check("R1 core0 private line", int'(bid[0 +: IW]), 20);
    check("R1 core1 private disabled", int'(irq[1]), 0);
  endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_trig();
    t_prio();
    t_mask();
    t_group();
    t_route();
    t_private();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule